// File: doc/BRIEF.md
# Shared-Memory Collision Arbiter

This block sits between the two independent access ports of a shared 1K x 8 memory and decides, on every clock, which port may touch a location that both ports are addressing at once. Each port brings an active-low enable, a read/write line (low means write) and a 10-bit address. When both ports are enabled on the same address, the port that was there first keeps access. The other port receives an active-low busy flag, its write strobe toward the array is suppressed, and the read data returned to it is frozen. A disabled port is treated as powered down and never takes part in a collision.

The array itself is outside the block. The block drives one registered write strobe per port toward the array. It takes the array's raw read data for each port and returns a registered, possibly held copy. In slave mode, local arbitration is bypassed: each port's busy comes in from a pin, is registered and echoed, and blocks that port's writes. All pins are plain level signals sampled on one clock. There is no stream handshake and no back-pressure, because every input is consumed on every edge and every output is a registered level.

Top module: `dpc_collision_arb`

## Requirements
- R1: In master mode (`slave_en`=0), a port's busy output goes low only when, at the previous clock edge, both enables were low and both addresses were equal.
- R2: When a collision begins, the winner is the port whose enable, read/write and address were unchanged from the edge before. If only one port changed, that port is the loser and gets busy.
- R3: If both ports changed at the edge where the collision begins, the left port wins and the right port is busy.
- R4: Once established, ownership is kept while the match persists, even if the loser toggles its read/write line.
- R5: Busy is released, seen as high one cycle later, when the addresses differ or either enable goes high.
- R6: A port's `mem_we` is 1 one cycle after an edge at which its enable was low, its read/write was low and it was not busy. Otherwise it is 0.
- R7: In slave mode (`slave_en`=1), each busy output is the registered value of that port's `busy_in_n`. A low `busy_in_n` forces that port's `mem_we` to 0, whatever the local arbitration state.
- R8: A port that is not busy returns `arr_rdata`, registered one cycle.
- R9: While a port stays busy and its enable, read/write and address are unchanged from the edge before, its `rd_data` holds its previous value. Any change of those inputs reloads `rd_data` from `arr_rdata` once.
- R10: After reset, both busy outputs are 1, both `mem_we` are 0, both `rd_data` are 0, and no port owns any location.
- R11: A port with a high enable causes busy to neither port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slave_en | input | 1 | 1 selects slave mode (busy taken from pins) |
| l_ce_n | input | 1 | Left enable, active low |
| l_rw_n | input | 1 | Left read/write, 0 = write |
| l_addr | input | 10 | Left address |
| l_busy_in_n | input | 1 | Left busy input for slave mode, active low |
| l_arr_rdata | input | 8 | Raw array read data for the left port |
| l_busy_n | output | 1 | Left busy, active low |
| l_mem_we | output | 1 | Gated left write strobe to the array |
| l_rd_data | output | 8 | Left read data, held while busy |
| r_ce_n | input | 1 | Right enable, active low |
| r_rw_n | input | 1 | Right read/write, 0 = write |
| r_addr | input | 10 | Right address |
| r_busy_in_n | input | 1 | Right busy input for slave mode, active low |
| r_arr_rdata | input | 8 | Raw array read data for the right port |
| r_busy_n | output | 1 | Right busy, active low |
| r_mem_we | output | 1 | Gated right write strobe to the array |
| r_rd_data | output | 8 | Right read data, held while busy |

## Verification
Every output is due exactly one clock edge after the inputs that decide it: busy, the gated write strobe and the held or reloaded read data all come from a single register stage. The bench changes inputs on the falling edge. A driver task computes the expected outputs for the coming rising edge and pushes them into a queue. A monitor pops and compares them 5 ns after that rising edge, so each comparison lands on the one cycle where the result is due. Reset values are checked directly before the first stimulus.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/dpc_port_track.sv
// Remembers one port's last sampled controls and flags any change.
module dpc_port_track #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              rw_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              active,
  output logic              changed
);
  localparam int CTL_W = ADDR_W + 2;

  logic [CTL_W-1:0] now_v;
  logic [CTL_W-1:0] prev_q;

  assign now_v   = {ce_n, rw_n, addr};
  assign active  = ~ce_n;
  assign changed = (now_v != prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= {2'b11, {ADDR_W{1'b0}}};
    else        prev_q <= now_v;
  end
endmodule

// File: rtl/dpc_owner_arb.sv
// Ownership register for a shared location: first arrival wins, left on a tie.
module dpc_owner_arb #(
  parameter int ADDR_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                act_l,
  input  logic                act_r,
  input  logic [ADDR_W-1:0]   addr_l,
  input  logic [ADDR_W-1:0]   addr_r,
  input  logic                chg_l,
  input  logic                chg_r,
  output dpc_pkg::owner_e     owner_nxt
);
  import dpc_pkg::*;

  owner_e own_q;
  logic   match;

  assign match = act_l & act_r & (addr_l == addr_r);

  always_comb begin
    owner_nxt = own_q;
    if (!match) begin
      owner_nxt = OWN_NONE;
    end else if (own_q == OWN_NONE) begin
      // the port that just moved is the late one
      if (chg_l && !chg_r) owner_nxt = OWN_RIGHT;
      else                 owner_nxt = OWN_LEFT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) own_q <= OWN_NONE;
    else        own_q <= owner_nxt;
  end
endmodule

// File: rtl/dpc_port_gate.sv
// Per-port output stage: busy select, write gating, read hold.
module dpc_port_gate #(
  parameter int              DATA_W = 8,
  parameter dpc_pkg::owner_e RIVAL  = dpc_pkg::OWN_RIGHT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slave_en,
  input  logic               busy_in_n,
  input  dpc_pkg::owner_e    owner_nxt,
  input  logic               ce_n,
  input  logic               rw_n,
  input  logic               changed,
  input  logic [DATA_W-1:0]  arr_rdata,
  output logic               busy_n,
  output logic               mem_we,
  output logic [DATA_W-1:0]  rd_data
);
  logic busy_eff;
  logic hold;

  assign busy_eff = slave_en ? ~busy_in_n : (owner_nxt == RIVAL);
  assign hold     = busy_eff & ~changed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_n  <= 1'b1;
      mem_we  <= 1'b0;
      rd_data <= '0;
    end else begin
      busy_n  <= ~busy_eff;
      mem_we  <= ~ce_n & ~rw_n & ~busy_eff;
      if (!hold) rd_data <= arr_rdata;
    end
  end
endmodule

// File: rtl/dpc_collision_arb.sv
module dpc_collision_arb #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave_en,
  input  logic              l_ce_n,
  input  logic              l_rw_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_busy_in_n,
  input  logic [DATA_W-1:0] l_arr_rdata,
  output logic              l_busy_n,
  output logic              l_mem_we,
  output logic [DATA_W-1:0] l_rd_data,
  input  logic              r_ce_n,
  input  logic              r_rw_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_busy_in_n,
  input  logic [DATA_W-1:0] r_arr_rdata,
  output logic              r_busy_n,
  output logic              r_mem_we,
  output logic [DATA_W-1:0] r_rd_data
);
  import dpc_pkg::*;

  localparam int NPORT = 2;

  logic              ce_a     [NPORT];
  logic              rw_a     [NPORT];
  logic [ADDR_W-1:0] addr_a   [NPORT];
  logic              bin_a    [NPORT];
  logic [DATA_W-1:0] ard_a    [NPORT];
  logic              act_a    [NPORT];
  logic              chg_a    [NPORT];
  logic              busy_a   [NPORT];
  logic              we_a     [NPORT];
  logic [DATA_W-1:0] rd_a     [NPORT];
  owner_e            owner_nxt;

  assign ce_a[0] = l_ce_n;      assign ce_a[1] = r_ce_n;
  assign rw_a[0] = l_rw_n;      assign rw_a[1] = r_rw_n;
  assign addr_a[0] = l_addr;    assign addr_a[1] = r_addr;
  assign bin_a[0] = l_busy_in_n; assign bin_a[1] = r_busy_in_n;
  assign ard_a[0] = l_arr_rdata; assign ard_a[1] = r_arr_rdata;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam owner_e RIVAL_P = (p == 0) ? OWN_RIGHT : OWN_LEFT;

    dpc_port_track #(.ADDR_W(ADDR_W)) track_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .ce_n    (ce_a[p]),
      .rw_n    (rw_a[p]),
      .addr    (addr_a[p]),
      .active  (act_a[p]),
      .changed (chg_a[p])
    );

    dpc_port_gate #(.DATA_W(DATA_W), .RIVAL(RIVAL_P)) gate_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .slave_en  (slave_en),
      .busy_in_n (bin_a[p]),
      .owner_nxt (owner_nxt),
      .ce_n      (ce_a[p]),
      .rw_n      (rw_a[p]),
      .changed   (chg_a[p]),
      .arr_rdata (ard_a[p]),
      .busy_n    (busy_a[p]),
      .mem_we    (we_a[p]),
      .rd_data   (rd_a[p])
    );
  end

  dpc_owner_arb #(.ADDR_W(ADDR_W)) arb_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .act_l     (act_a[0]),
    .act_r     (act_a[1]),
    .addr_l    (addr_a[0]),
    .addr_r    (addr_a[1]),
    .chg_l     (chg_a[0]),
    .chg_r     (chg_a[1]),
    .owner_nxt (owner_nxt)
  );

  assign l_busy_n  = busy_a[0];
  assign l_mem_we  = we_a[0];
  assign l_rd_data = rd_a[0];
  assign r_busy_n  = busy_a[1];
  assign r_mem_we  = we_a[1];
  assign r_rd_data = rd_a[1];
endmodule

// File: rtl/dpc_collision_arb_chk.sv
module dpc_collision_arb_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slave_en,
  input logic              l_ce_n,
  input logic              l_rw_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_busy_in_n,
  input logic [DATA_W-1:0] l_arr_rdata,
  input logic              l_busy_n,
  input logic              l_mem_we,
  input logic [DATA_W-1:0] l_rd_data,
  input logic              r_ce_n,
  input logic              r_rw_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_busy_in_n,
  input logic [DATA_W-1:0] r_arr_rdata,
  input logic              r_busy_n,
  input logic              r_mem_we,
  input logic [DATA_W-1:0] r_rd_data
);
  logic same_loc;
  assign same_loc = !l_ce_n && !r_ce_n && (l_addr == r_addr);

  a_r1_busy_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(slave_en) && (!l_busy_n || !r_busy_n)) |-> $past(same_loc));

  a_r2_single_loser: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(slave_en) |-> !(!l_busy_n && !r_busy_n));

  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(slave_en) && !$past(same_loc)) |-> (l_busy_n && r_busy_n));

  a_r6_we_left: assert property (@(posedge clk) disable iff (!rst_n)
    l_mem_we |-> $past(!l_ce_n && !l_rw_n));

  a_r6_we_right: assert property (@(posedge clk) disable iff (!rst_n)
    r_mem_we |-> $past(!r_ce_n && !r_rw_n));

  a_r7_slave_block: assert property (@(posedge clk) disable iff (!rst_n)
    $past(slave_en && !l_busy_in_n) |-> !l_mem_we);

  a_r9_hold_left: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_busy_n && $past(rst_n, 2) &&
     $past({l_ce_n, l_rw_n, l_addr}) == $past({l_ce_n, l_rw_n, l_addr}, 2))
    |-> (l_rd_data == $past(l_rd_data)));

  a_r11_idle_left: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(slave_en) && $past(l_ce_n)) |-> (l_busy_n && r_busy_n));
endmodule

bind dpc_collision_arb dpc_collision_arb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/dpc_collision_arb_tb_top.sv
`timescale 1ns/1ps
module dpc_collision_arb_tb_top;
  localparam int AW = 10;
  localparam int DW = 8;

  typedef struct {
    logic          bl, br, wl, wr;
    logic [DW-1:0] dl, dr;
    string         tag;
  } exp_t;

  logic clk = 0;
  logic rst_n = 0;
  logic slave_en = 0;
  logic l_ce_n = 1, l_rw_n = 1, l_busy_in_n = 1;
  logic r_ce_n = 1, r_rw_n = 1, r_busy_in_n = 1;
  logic [AW-1:0] l_addr = 0, r_addr = 0;
  logic [DW-1:0] l_arr_rdata = 0, r_arr_rdata = 0;
  logic l_busy_n, l_mem_we, r_busy_n, r_mem_we;
  logic [DW-1:0] l_rd_data, r_rd_data;

  int checks = 0;
  int errors = 0;
  exp_t q[$];

  // reference state
  int            m_own = 0; // 0 none, 1 left, 2 right
  logic [AW+1:0] m_pl = {2'b11, {AW{1'b0}}};
  logic [AW+1:0] m_pr = {2'b11, {AW{1'b0}}};
  logic [DW-1:0] m_dl = 0, m_dr = 0;

  always #10 clk = ~clk;

  dpc_collision_arb #(.ADDR_W(AW), .DATA_W(DW)) dut_i (.*);

  task automatic drive(input logic cel, input logic rwl, input logic [AW-1:0] al,
                       input logic [DW-1:0] dl, input logic cer, input logic rwr,
                       input logic [AW-1:0] ar, input logic [DW-1:0] dr,
                       input logic slv, input logic bil, input logic bir,
                       input string tag);
    exp_t e;
    logic match, chl, chr, bsl, bsr;
    @(negedge clk);
    l_ce_n = cel; l_rw_n = rwl; l_addr = al; l_arr_rdata = dl;
    r_ce_n = cer; r_rw_n = rwr; r_addr = ar; r_arr_rdata = dr;
    slave_en = slv; l_busy_in_n = bil; r_busy_in_n = bir;
    match = !cel && !cer && (al == ar);
    chl = ({cel, rwl, al} != m_pl);
    chr = ({cer, rwr, ar} != m_pr);
    if (!match) m_own = 0;
    else if (m_own == 0) m_own = (chl && !chr) ? 2 : 1;
    bsl = slv ? !bil : (m_own == 2);
    bsr = slv ? !bir : (m_own == 1);
    if (!(bsl && !chl)) m_dl = dl;
    if (!(bsr && !chr)) m_dr = dr;
    m_pl = {cel, rwl, al};
    m_pr = {cer, rwr, ar};
    e.bl = !bsl; e.br = !bsr;
    e.wl = !cel && !rwl && !bsl;
    e.wr = !cer && !rwr && !bsr;
    e.dl = m_dl; e.dr = m_dr; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: results are due at the rising edge after the drive
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (l_busy_n !== e.bl || r_busy_n !== e.br || l_mem_we !== e.wl ||
          r_mem_we !== e.wr || l_rd_data !== e.dl || r_rd_data !== e.dr) begin
        errors++;
        $display("FAIL %s: got bl=%b br=%b wl=%b wr=%b dl=%h dr=%h exp bl=%b br=%b wl=%b wr=%b dl=%h dr=%h",
                 e.tag, l_busy_n, r_busy_n, l_mem_we, r_mem_we, l_rd_data, r_rd_data,
                 e.bl, e.br, e.wl, e.wr, e.dl, e.dr);
      end
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    checks++;
    if (l_busy_n !== 1 || r_busy_n !== 1 || l_mem_we !== 0 || r_mem_we !== 0 ||
        l_rd_data !== 0 || r_rd_data !== 0) begin
      errors++;
      $display("FAIL R10 reset: got bl=%b br=%b wl=%b wr=%b dl=%h dr=%h exp 1 1 0 0 00 00",
               l_busy_n, r_busy_n, l_mem_we, r_mem_we, l_rd_data, r_rd_data);
    end
    @(negedge clk) rst_n = 1;

    // R8 R11: left reads alone, right disabled on the same address
    drive(0,1,10'd5,8'hA1, 1,1,10'd5,8'h11, 0,1,1, "R8 R11 left alone");
    drive(0,1,10'd5,8'hA2, 1,1,10'd5,8'h12, 0,1,1, "R8 R11 left alone 2");
    // R2 R1 R6: right arrives late and tries to write -> busy, write blocked
    drive(0,1,10'd5,8'hA3, 0,0,10'd5,8'h20, 0,1,1, "R2 R1 R6 right late");
    // R6 R9: left writes, right held
    drive(0,0,10'd5,8'hA4, 0,0,10'd5,8'h21, 0,1,1, "R6 R9 left writes hold");
    drive(0,0,10'd5,8'hA5, 0,0,10'd5,8'h22, 0,1,1, "R9 right still held");
    // R4 R9: loser toggles rw -> still busy, reload once
    drive(0,0,10'd5,8'hA6, 0,1,10'd5,8'h23, 0,1,1, "R4 R9 toggle reload");
    drive(0,0,10'd5,8'hA7, 0,1,10'd5,8'h24, 0,1,1, "R4 R9 held again");
    // R5 R8: left moves away -> release
    drive(0,1,10'd6,8'hA8, 0,1,10'd5,8'h25, 0,1,1, "R5 R8 addr release");
    // R2: right owns 9 first, left arrives
    drive(0,1,10'd3,8'hB0, 0,1,10'd9,8'h30, 0,1,1, "R1 no match");
    drive(0,0,10'd9,8'hB1, 0,1,10'd9,8'h31, 0,1,1, "R2 left late");
    drive(0,0,10'd9,8'hB2, 0,1,10'd9,8'h32, 0,1,1, "R2 R9 left held");
    // R5 R11: winner disables
    drive(0,0,10'd9,8'hB3, 1,1,10'd9,8'h33, 0,1,1, "R5 R11 ce release");
    // R3: both arrive together
    drive(1,1,10'd0,8'hC0, 1,1,10'd0,8'h40, 0,1,1, "R11 both idle");
    drive(0,0,10'd12,8'hC1, 0,0,10'd12,8'h41, 0,1,1, "R3 tie left wins");
    drive(0,0,10'd12,8'hC2, 0,0,10'd12,8'h42, 0,1,1, "R3 R4 tie held");
    // R1: different addresses, both write
    drive(0,0,10'd1,8'hC3, 0,0,10'd2,8'h43, 0,1,1, "R1 R6 both write");
    // R7: slave mode
    drive(0,0,10'd7,8'hD0, 0,0,10'd8,8'h50, 1,0,1, "R7 slave left blocked");
    drive(0,0,10'd7,8'hD1, 0,0,10'd7,8'h51, 1,1,1, "R7 slave no local arb");
    drive(0,0,10'd7,8'hD2, 0,0,10'd7,8'h52, 1,1,0, "R7 slave right blocked");
    drive(1,1,10'd0,8'h00, 1,1,10'd0,8'h00, 0,1,1, "R11 quiet");
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule